// File: doc/BRIEF.md
# Johnson Decade Counter with One-Hot Decoder

This block counts rising clock edges in a five-stage twisted-ring register. The ring walks through ten distinct codes, and each code lights exactly one of ten decimal outputs. Each decimal output is a two-input gate on a pair of neighbouring ring bits. Between any two codes in the sequence only one ring bit changes, so a decoded line cannot pulse falsely while the ring moves from one code to the next.

A carry line comes straight from the top ring bit. It is high for the first half of the cycle and low for the second half, so the cycle is a square wave. Its rising edge marks each completed cycle, which lets one counter clock the next decade. A clock-inhibit input freezes the count.

The build-time parameter `MODULUS` (2 to 10) sets the cycle length. The decoded line for count `MODULUS-1` is fed back, and on the next advancing edge it returns the ring to count 0. Any ring code outside the legal sequence is forced back to count 0 on the next advancing edge.

The reset input is active low and clears the count at once. Its release is passed through two flops, so counting begins on the third rising edge after the release.

Top module: `johnson_decade`

## Requirements
- R1: While `rst_n` is low, the block shows count 0 without waiting for a clock: `dec_o` = 10'b0000000001 and `carry_o` = 1.
- R2: In every cycle after reset, exactly one bit of `dec_o` is high. Bit k is high during count k.
- R3: With `MODULUS` = 10, each rising edge with `inhibit_i` low moves the count from k to k+1, and from 9 back to 0.
- R4: A rising edge with `inhibit_i` high leaves `dec_o` and `carry_o` unchanged.
- R5: `carry_o` is 1 during counts 0 to 4 and 0 during counts 5 to 9. It rises only on the edge where the count enters 0.
- R6: For `MODULUS` = N with 2 ≤ N ≤ 10, the count runs 0, 1, …, N-1 and then returns to 0. The cycle is exactly N advancing edges long. With N ≤ 5, `carry_o` stays 1.
- R7: After `rst_n` rises, the first two rising edges leave the count at 0. The third rising edge, with `inhibit_i` low, advances it to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count changes only on its rising edge |
| rst_n | input | 1 | Reset, active low; takes effect at once, its release is synchronized |
| inhibit_i | input | 1 | When high, rising clock edges do not advance the count |
| dec_o | output | 10 | One-hot decimal outputs; bit k is high during count k |
| carry_o | output | 1 | Square-wave carry, high during counts 0 to 4 |

## Verification
Three properties rely on the ring holding a legal code in every clocked cycle after reset: the one-hot check, the shift-by-one check and the wrap check. That can only fail if the register is disturbed by something other than its ports, so the bench never forces illegal codes. The properties also assume `inhibit_i` is steady around each rising edge. The bench changes `inhibit_i` only on falling edges, and changes `rst_n` only away from rising edges. Three copies of the block run side by side with `MODULUS` set to 10, 4 and 2, and all of them get the same stimulus.

// File: rtl/jdc_pkg.sv
package jdc_pkg;
  localparam int unsigned STAGES = 5;
  localparam int unsigned COUNTS = 2 * STAGES;
  typedef logic [STAGES-1:0] ring_t;
  typedef logic [COUNTS-1:0] dec_t;
endpackage

// File: rtl/jdc_reset_sync.sv
module jdc_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      stage1 <= 1'b1;
      srst_n <= stage1;
    end
  end
endmodule

// File: rtl/jdc_ring.sv
module jdc_ring
  import jdc_pkg::*;
(
  input  logic  clk,
  input  logic  srst_n,
  input  logic  adv_en,
  input  logic  wrap,
  output ring_t q
);
  localparam int unsigned PAIRS = STAGES - 1;

  ring_t nxt;
  logic  legal;
  int unsigned edges;

  // A legal twisted-ring code has at most one 0/1 boundary along its bits.
  always_comb begin
    edges = 0;
    for (int i = 0; i < PAIRS; i++) begin
      if (q[i] != q[i+1]) edges = edges + 1;
    end
    legal = (edges <= 1);
  end

  always_comb begin
    if (!legal || wrap) nxt = '0;
    else                nxt = {q[STAGES-2:0], ~q[STAGES-1]};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     q <= '0;
    else if (adv_en) q <= nxt;
  end

  // R4: an inhibited edge keeps the ring frozen
  assert_inhibit_hold_R4: assert property (@(posedge clk) disable iff (!srst_n)
    !adv_en |=> $stable(q));

  // R2: the ring only ever holds codes with at most one boundary
  assert_ring_legal_R2: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(q ^ {q[STAGES-2:0], q[0]}) <= 1);
endmodule

// File: rtl/jdc_decode.sv
module jdc_decode
  import jdc_pkg::*;
(
  input  logic  clk,
  input  logic  srst_n,
  input  ring_t q,
  output dec_t  dec
);
  genvar k;
  generate
    for (k = 0; k < COUNTS; k++) begin : g_line
      if (k == 0) begin : g_zero
        assign dec[k] = ~q[STAGES-1] & ~q[0];
      end else if (k < STAGES) begin : g_fill
        assign dec[k] = q[k-1] & ~q[k];
      end else if (k == STAGES) begin : g_full
        assign dec[k] = q[STAGES-1] & q[0];
      end else begin : g_drain
        assign dec[k] = ~q[k-STAGES-1] & q[k-STAGES];
      end
    end
  endgenerate

  // R2: exactly one decimal line is lit
  assert_dec_onehot_R2: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot(dec));
endmodule

// File: rtl/johnson_decade.sv
module johnson_decade
  import jdc_pkg::*;
#(
  parameter int unsigned MODULUS = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inhibit_i,
  output logic [9:0]   dec_o,
  output logic         carry_o
);
  localparam int unsigned LAST = MODULUS - 1;

  logic  srst_n;
  logic  adv_en;
  logic  wrap;
  ring_t q;
  dec_t  dec;

  jdc_reset_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  assign adv_en = ~inhibit_i;
  assign wrap   = dec[LAST];

  jdc_ring u_ring (
    .clk    (clk),
    .srst_n (srst_n),
    .adv_en (adv_en),
    .wrap   (wrap),
    .q      (q)
  );

  jdc_decode u_dec (
    .clk    (clk),
    .srst_n (srst_n),
    .q      (q),
    .dec    (dec)
  );

  assign dec_o   = dec;
  assign carry_o = ~q[STAGES-1];

  // R6: the last count of the cycle returns to count 0
  assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (adv_en && dec_o[LAST]) |=> dec_o[0]);

  // R3: any other advancing edge moves the lit line up by one
  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (adv_en && !dec_o[LAST]) |=> (dec_o == ($past(dec_o) << 1)));

  // R5: the carry rises only when the count enters 0
  assert_carry_rise_R5: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(carry_o) |-> dec_o[0]);
endmodule

// File: tb/johnson_decade_test.sv
module johnson_decade_test;
  localparam int PERIOD = 10;
  localparam int NVEC = 40;
  // inhibit pattern applied one entry per clock; expected counts follow the model
  localparam bit [NVEC-1:0] INH = 40'b0000_0000_0010_0110_0000_0000_1100_0000_0000_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic inhibit_i;
  logic [9:0] dec_a, dec_b, dec_c;
  logic carry_a, carry_b, carry_c;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int c10, c4, c2;

  always #(PERIOD/2) clk = ~clk;

  johnson_decade #(.MODULUS(10)) uut (
    .clk(clk), .rst_n(rst_n), .inhibit_i(inhibit_i), .dec_o(dec_a), .carry_o(carry_a));
  johnson_decade #(.MODULUS(4)) uut_d4 (
    .clk(clk), .rst_n(rst_n), .inhibit_i(inhibit_i), .dec_o(dec_b), .carry_o(carry_b));
  johnson_decade #(.MODULUS(2)) uut_d2 (
    .clk(clk), .rst_n(rst_n), .inhibit_i(inhibit_i), .dec_o(dec_c), .carry_o(carry_c));

  task automatic check(string req, logic [10:0] act, logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [10:0] model(int c);
    logic [9:0] d;
    d = 10'd1 << c;
    return {(c < 5) ? 1'b1 : 1'b0, d};
  endfunction

  task automatic check_all(string req);
    check({req, " N=10"}, {carry_a, dec_a}, model(c10));
    check({req, " N=4"},  {carry_b, dec_b}, model(c4));
    check({req, " N=2"},  {carry_c, dec_c}, model(c2));
  endtask

  task automatic step(bit inh, string req);
    @(negedge clk);
    inhibit_i = inh;
    @(posedge clk);
    if (!inh) begin
      c10 = (c10 + 1) % 10;
      c4  = (c4 + 1) % 4;
      c2  = (c2 + 1) % 2;
    end
    #1;
    check_all(req);
  endtask

  initial begin
    rst_n = 1'b1;
    inhibit_i = 1'b1;
    c10 = 0; c4 = 0; c2 = 0;
    #1 rst_n = 1'b0;
    #1;
    check_all("R1 async reset");
    repeat (3) @(posedge clk);
    #1 check_all("R1 held in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 check_all("R1 after release");

    // vector walk: R2 R3 R4 R5 R6 together
    for (int i = 0; i < NVEC; i++) begin
      step(INH[i], INH[i] ? "R4 inhibit hold" : "R3 R5 R6 R2 advance");
    end

    // directed: full wrap and carry rise at count 0
    while (c10 != 9) step(1'b0, "R3 approach 9");
    check({"R5 carry low at 9"}, {10'd0, carry_a}, 11'd0);
    step(1'b0, "R5 carry rises at wrap");
    check("R5 carry rose", {10'd0, carry_a}, 11'd1);
    check("R3 wrap to 0", {1'b0, dec_a}, 11'd1);

    // directed: inhibit across a wrap point
    while (c4 != 3) step(1'b0, "R6 approach N-1");
    step(1'b1, "R4 inhibit at N-1");
    step(1'b0, "R6 wrap at N");

    // directed: asynchronous reset mid-count, then release timing
    step(1'b0, "R3 move off zero");
    @(posedge clk);
    #3 rst_n = 1'b0;
    c10 = 0; c4 = 0; c2 = 0;
    #1 check_all("R1 async reset mid-count");
    @(negedge clk);
    inhibit_i = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #1 check_all("R7 first edge held");
    @(posedge clk); #1 check_all("R7 second edge held");
    @(posedge clk);
    c10 = 1; c4 = 1; c2 = 1;
    #1 check_all("R7 third edge advances");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule